// File: doc/BRIEF.md
# Shared-Bus Dual-Bank Select Decoder

This block sits in front of one shared address and data bus that serves two memory banks: a flash bank and an SRAM bank. It takes the bank enables (one active-low enable for flash, and a pair for SRAM: one active-low, one active-high), the write and output enables, the two active-low byte selects and the word address. From these it produces per-bank read and write strobes, byte-lane enables for SRAM accesses, a standby indication and the enable for the data bus output driver. All of these outputs are registered.

Two error conditions are reported. If both banks are enabled at once, the block drives neither bank and sets a sticky contention flag. The flag stays set until the synchronous clear input is pulsed. An SRAM access whose address lies beyond the configured SRAM depth is not passed on to the bank, and it raises a one-cycle out-of-range pulse. The SRAM occupies the lowest words of the shared address space. Its depth is a parameter: 256K words by default, 512K words as the other setting.

All ports are plain level signals. There is no valid/ready handshake: every clock edge samples the bus state, and the result appears on the outputs one cycle later.

Top module: `dual_bank_sel`

## Requirements
- R1: With the flash bank selected (`flash_sel_n`=0, SRAM not selected), `oe_n`=0 and `we_n`=1, `flash_rd` is 1 one clock edge later. Otherwise `flash_rd` is 0.
- R2: With the flash bank selected alone, `we_n`=0 and `oe_n`=1, `flash_wr` is 1 one clock edge later. If `oe_n` is 0 while `we_n` is 0, the write is inhibited and `flash_wr` stays 0.
- R3: The SRAM bank counts as selected only when `sram_sel_n`=0 and `sram_sel`=1. An SRAM read (`oe_n`=0, `we_n`=1) raises `sram_rd`. An SRAM write (`we_n`=0) raises `sram_wr`. Both appear one edge later.
- R4: `standby` is 1 one edge after neither bank is selected: `flash_sel_n`=1, and either `sram_sel_n`=1 or `sram_sel`=0. While in standby, all strobes are 0.
- R5: When both banks are selected in the same cycle, all strobes, both lane enables and `bus_oe` are 0 one edge later, and `contention_err` is 1.
- R6: `contention_err` stays 1 until a cycle with `err_clr`=1 and no contention, after which it reads 0. If a clear and a new contention occur in the same cycle, the flag stays 1.
- R7: `bus_oe` is 1 only together with `flash_rd` or `sram_rd`. It is never 1 for a cycle in which `oe_n` was 1.
- R8: During an SRAM access, `ub_n`=0 raises `sram_ub_en` and `lb_n`=0 raises `sram_lb_en`. With both byte selects at 1, no SRAM strobe, no lane enable and no `bus_oe` is produced.
- R9: An SRAM read or write with `addr` ≥ `SRAM_DEPTH` gives no SRAM strobe or lane enable. Instead `range_err` is 1 for one cycle. Addresses `SRAM_DEPTH-1` and below are accepted.
- R10: While `rst_n` is 0, all strobes, both lane enables, `bus_oe`, `range_err` and `contention_err` are 0, and `standby` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_clr | input | 1 | Synchronous clear of the contention flag |
| flash_sel_n | input | 1 | Flash bank enable, active low |
| sram_sel_n | input | 1 | SRAM bank enable, active low |
| sram_sel | input | 1 | SRAM bank enable, active high |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| ub_n | input | 1 | Upper byte select, active low |
| lb_n | input | 1 | Lower byte select, active low |
| addr | input | ADDR_W | Shared word address |
| flash_rd | output | 1 | Flash read strobe |
| flash_wr | output | 1 | Flash write strobe |
| sram_rd | output | 1 | SRAM read strobe |
| sram_wr | output | 1 | SRAM write strobe |
| sram_ub_en | output | 1 | SRAM upper byte lane enable |
| sram_lb_en | output | 1 | SRAM lower byte lane enable |
| standby | output | 1 | No bank selected |
| bus_oe | output | 1 | Data bus output driver enable |
| range_err | output | 1 | SRAM address beyond configured depth |
| contention_err | output | 1 | Sticky dual-select error flag |

## Verification
Two functions can fall in the same cycle: a pulse on the contention flag's clear input and a fresh dual-bank select. The bench provokes this by driving both enables low, with `sram_sel` high, in the very cycle in which `err_clr` is raised. It judges the result one edge later: the flag must still read 1, and all strobes must be 0. A following cycle with only the clear then shows the flag falling to 0, which proves that the clear path works on its own.

// File: rtl/dbs_pkg.sv
package dbs_pkg;
  typedef struct packed {
    logic flash_rd;
    logic flash_wr;
    logic sram_rd;
    logic sram_wr;
    logic ub_en;
    logic lb_en;
    logic standby;
    logic bus_oe;
    logic range_err;
  } dbs_out_t;

  localparam dbs_out_t DBS_RESET = '{standby: 1'b1, default: 1'b0};
endpackage

// File: rtl/dbs_bank_decode.sv
module dbs_bank_decode (
  input  logic flash_sel_n,
  input  logic sram_sel_n,
  input  logic sram_sel,
  input  logic we_n,
  input  logic oe_n,
  output logic flash_rd,
  output logic flash_wr,
  output logic sram_go,
  output logic rd_req,
  output logic wr_req,
  output logic idle,
  output logic conflict
);
  logic f_on, s_on;

  always_comb begin
    f_on     = ~flash_sel_n;
    s_on     = ~sram_sel_n & sram_sel;
    conflict = f_on & s_on;
    idle     = ~f_on & ~s_on;
    rd_req   = ~oe_n & we_n;
    wr_req   = ~we_n;
    flash_rd = f_on & ~conflict & rd_req;
    // an active output enable inhibits flash writes
    flash_wr = f_on & ~conflict & wr_req & oe_n;
    sram_go  = s_on & ~conflict;
  end
endmodule

// File: rtl/dbs_lane_gate.sv
module dbs_lane_gate #(
  parameter int ADDR_W     = 21,
  parameter int SRAM_DEPTH = 262144
) (
  input  logic              sram_go,
  input  logic              rd_req,
  input  logic              wr_req,
  input  logic              ub_n,
  input  logic              lb_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              sram_rd,
  output logic              sram_wr,
  output logic              ub_en,
  output logic              lb_en,
  output logic              range_err
);
  localparam logic [ADDR_W:0] LIMIT = (ADDR_W + 1)'(SRAM_DEPTH);

  logic in_range, any_lane, try_acc;

  generate
    if (SRAM_DEPTH >= (1 << ADDR_W)) begin : g_full
      assign in_range = 1'b1;
    end else begin : g_window
      assign in_range = ({1'b0, addr} < LIMIT);
    end
  endgenerate

  always_comb begin
    any_lane  = ~ub_n | ~lb_n;
    try_acc   = sram_go & (rd_req | wr_req);
    sram_rd   = sram_go & in_range & any_lane & rd_req;
    sram_wr   = sram_go & in_range & any_lane & wr_req;
    ub_en     = (sram_rd | sram_wr) & ~ub_n;
    lb_en     = (sram_rd | sram_wr) & ~lb_n;
    range_err = try_acc & ~in_range;
  end
endmodule

// File: rtl/dbs_err_latch.sv
module dbs_err_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (set) flag <= 1'b1;   // a new event outranks a clear
    else if (clr) flag <= 1'b0;
  end

  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag); // R6
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> flag); // R6
endmodule

// File: rtl/dual_bank_sel.sv
module dual_bank_sel #(
  parameter int ADDR_W     = 21,
  parameter int SRAM_DEPTH = 262144
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              err_clr,
  input  logic              flash_sel_n,
  input  logic              sram_sel_n,
  input  logic              sram_sel,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              ub_n,
  input  logic              lb_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              flash_rd,
  output logic              flash_wr,
  output logic              sram_rd,
  output logic              sram_wr,
  output logic              sram_ub_en,
  output logic              sram_lb_en,
  output logic              standby,
  output logic              bus_oe,
  output logic              range_err,
  output logic              contention_err
);
  import dbs_pkg::*;

  logic f_rd, f_wr, s_go, rd_req, wr_req, idle, conflict;
  logic s_rd, s_wr, ub_c, lb_c, rng_c;
  dbs_out_t nxt, q;

  dbs_bank_decode u_dec (
    .flash_sel_n(flash_sel_n), .sram_sel_n(sram_sel_n), .sram_sel(sram_sel),
    .we_n(we_n), .oe_n(oe_n),
    .flash_rd(f_rd), .flash_wr(f_wr), .sram_go(s_go),
    .rd_req(rd_req), .wr_req(wr_req), .idle(idle), .conflict(conflict)
  );

  dbs_lane_gate #(.ADDR_W(ADDR_W), .SRAM_DEPTH(SRAM_DEPTH)) u_lane (
    .sram_go(s_go), .rd_req(rd_req), .wr_req(wr_req),
    .ub_n(ub_n), .lb_n(lb_n), .addr(addr),
    .sram_rd(s_rd), .sram_wr(s_wr), .ub_en(ub_c), .lb_en(lb_c),
    .range_err(rng_c)
  );

  dbs_err_latch u_err (
    .clk(clk), .rst_n(rst_n), .set(conflict), .clr(err_clr),
    .flag(contention_err)
  );

  always_comb begin
    nxt.flash_rd  = f_rd;
    nxt.flash_wr  = f_wr;
    nxt.sram_rd   = s_rd;
    nxt.sram_wr   = s_wr;
    nxt.ub_en     = ub_c;
    nxt.lb_en     = lb_c;
    nxt.standby   = idle;
    nxt.bus_oe    = f_rd | s_rd;
    nxt.range_err = rng_c;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= DBS_RESET;
    else        q <= nxt;
  end

  assign flash_rd   = q.flash_rd;
  assign flash_wr   = q.flash_wr;
  assign sram_rd    = q.sram_rd;
  assign sram_wr    = q.sram_wr;
  assign sram_ub_en = q.ub_en;
  assign sram_lb_en = q.lb_en;
  assign standby    = q.standby;
  assign bus_oe     = q.bus_oe;
  assign range_err  = q.range_err;

  AST_ONE_BANK_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !((flash_rd || flash_wr) && (sram_rd || sram_wr))); // R5
  AST_DUAL_SELECT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (!flash_sel_n && !sram_sel_n && sram_sel) |=> (contention_err && !bus_oe)); // R5
  AST_DRIVE_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> (flash_rd || sram_rd)); // R7
  AST_OE_HIGH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |=> !bus_oe); // R7
  AST_LANE_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    (sram_ub_en || sram_lb_en) |-> (sram_rd || sram_wr)); // R8
  AST_RANGE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    range_err |-> !(sram_rd || sram_wr || sram_ub_en || sram_lb_en)); // R9
  AST_STANDBY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    standby |-> !(flash_rd || flash_wr || sram_rd || sram_wr || bus_oe)); // R4
  AST_RD_WR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(sram_rd && sram_wr) && !(flash_rd && flash_wr)); // R3
endmodule

// File: tb/dual_bank_sel_bench.sv
`timescale 1ns/1ps
module dual_bank_sel_bench;
  localparam int AW = 21;
  localparam int DEPTH = 262144;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic err_clr = 1'b0;
  logic flash_sel_n = 1'b1, sram_sel_n = 1'b1, sram_sel = 1'b0;
  logic we_n = 1'b1, oe_n = 1'b1, ub_n = 1'b1, lb_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic flash_rd, flash_wr, sram_rd, sram_wr, sram_ub_en, sram_lb_en;
  logic standby, bus_oe, range_err, contention_err;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dual_bank_sel #(.ADDR_W(AW), .SRAM_DEPTH(DEPTH)) u_dual_bank_sel (
    .clk(clk), .rst_n(rst_n), .err_clr(err_clr),
    .flash_sel_n(flash_sel_n), .sram_sel_n(sram_sel_n), .sram_sel(sram_sel),
    .we_n(we_n), .oe_n(oe_n), .ub_n(ub_n), .lb_n(lb_n), .addr(addr),
    .flash_rd(flash_rd), .flash_wr(flash_wr), .sram_rd(sram_rd), .sram_wr(sram_wr),
    .sram_ub_en(sram_ub_en), .sram_lb_en(sram_lb_en), .standby(standby),
    .bus_oe(bus_oe), .range_err(range_err), .contention_err(contention_err)
  );

  // vector order: flash_rd flash_wr sram_rd sram_wr ub_en lb_en standby bus_oe range_err
  function automatic logic [8:0] outs();
    return {flash_rd, flash_wr, sram_rd, sram_wr, sram_ub_en, sram_lb_en,
            standby, bus_oe, range_err};
  endfunction

  task automatic chk_vec(string req, logic [8:0] exp);
    checks++;
    if (outs() !== exp) begin
      failures++;
      $display("FAIL %s outputs actual=%b expected=%b", req, outs(), exp);
    end
  endtask

  task automatic chk_err(string req, logic exp);
    checks++;
    if (contention_err !== exp) begin
      failures++;
      $display("FAIL %s contention_err actual=%b expected=%b", req, contention_err, exp);
    end
  endtask

  // drive at negedge, let one posedge pass, return at next negedge
  task automatic step(logic fn, logic sn, logic sh, logic w, logic o,
                      logic u, logic l, logic [AW-1:0] a, logic c);
    flash_sel_n = fn; sram_sel_n = sn; sram_sel = sh;
    we_n = w; oe_n = o; ub_n = u; lb_n = l; addr = a; err_clr = c;
    @(negedge clk);
  endtask

  task automatic t_reset();
    step(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, '0, 1'b0);
    chk_vec("R10", 9'b000000100);
    chk_err("R10", 1'b0);
    rst_n = 1'b1;
  endtask

  task automatic t_flash();
    step(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 21'h1ABCDE, 1'b0);
    chk_vec("R1", 9'b100000010);
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 21'h000010, 1'b0);
    chk_vec("R2", 9'b010000000);
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 21'h000010, 1'b0);
    chk_vec("R2 inhibit", 9'b000000000);
    step(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 21'h000010, 1'b0);
    chk_vec("R7 oe high", 9'b000000000);
  endtask

  task automatic t_sram();
    step(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 21'h03FFFF, 1'b0);
    chk_vec("R3 read", 9'b001011010);
    step(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 21'h000123, 1'b0);
    chk_vec("R8 upper write", 9'b000110000);
    step(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 21'h000124, 1'b0);
    chk_vec("R8 lower read", 9'b001001010);
    step(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 21'h000124, 1'b0);
    chk_vec("R8 no lane", 9'b000000000);
    step(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 21'h000124, 1'b0);
    chk_vec("R3 high enable low", 9'b000000100);
  endtask

  task automatic t_standby();
    step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 21'h000001, 1'b0);
    chk_vec("R4", 9'b000000100);
  endtask

  task automatic t_range();
    step(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 21'h040000, 1'b0);
    chk_vec("R9 read", 9'b000000001);
    step(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 21'h1FFFFF, 1'b0);
    chk_vec("R9 write", 9'b000000001);
  endtask

  task automatic t_contention();
    step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 21'h000005, 1'b0);
    chk_vec("R5", 9'b000000000);
    chk_err("R5", 1'b1);
    step(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, '0, 1'b0);
    chk_err("R6 sticky", 1'b1);
    step(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, '0, 1'b1);
    chk_err("R6 clear", 1'b0);
  endtask

  task automatic t_clear_race();
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 21'h000007, 1'b1);
    chk_vec("R6 race", 9'b000000000);
    chk_err("R6 race", 1'b1);
    step(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, '0, 1'b1);
    chk_err("R6 after race", 1'b0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_flash();
    t_sram();
    t_standby();
    t_range();
    t_contention();
    t_clear_race();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule